// File: doc/BRIEF.md
# Stereo Serial-Word Input Front End for a Segmented DAC

This block receives two 18-bit audio sample streams over serial lines and prepares each one for a segmented resistor-ladder converter. Each channel has its own data line and latch strobe. Both channels share one bit clock. All of these pins are asynchronous to the block's system clock. Each one passes through a two-flop synchronizer, and edges are found on the synchronized copies.

On every rising bit-clock edge, each channel shifts its data bit into an input word, MSB first. When a channel's latch strobe falls, the input word moves into that channel's holding register. The held word is two's complement. Its four top bits, with the sign bit inverted to give offset binary, become a 15-wire thermometer code of equally weighted segments. The remaining 14 bits go out unchanged as a binary field. Each transfer raises a one-cycle update pulse.

The two latch strobes may be tied together so that both channels update on the same cycle. The two data lines may also be tied together, so that each channel captures whatever word is in flight when its own strobe falls.

Latch tracking in each channel is a two-state machine:
- In `LT_WAIT_HIGH`, the machine waits for the strobe to go high and then moves to `LT_ARMED` (transition *arm*).
- In `LT_ARMED`, a low strobe triggers the transfer and a return to `LT_WAIT_HIGH` (transition *fire*).
- Reset enters `LT_WAIT_HIGH`.

Top module: `dacif_front`

## Requirements
- R1: A synchronous active-high reset sets both held words to 0 (midscale). While reset is held and after it is released, each segment output reads 15'h00FF, each binary field reads 0, and each update pulse is low.
- R2: Data bits enter MSB first, one per rising bit-clock edge. A transfer captures the last 18 bits shifted in, and any earlier bits are discarded.
- R3: Only a falling latch edge, seen after the strobe has been high, transfers a word. A steady strobe, a rising strobe, or bit-clock activity without a latch edge leaves the outputs unchanged.
- R4: Each transfer raises that channel's update pulse for exactly one cycle, in the same cycle as the new outputs. Outside that pulse the channel's outputs hold steady.
- R5: Let k be the held word's bits [17:14] with bit 17 inverted, read as an unsigned number from 0 to 15. The segment output has bits 0 to k-1 set and all higher bits clear.
- R6: The binary output equals bits [13:0] of the held word.
- R7: The channels are independent: a latch edge on one channel does not change the other channel's outputs.
- R8: When both strobes fall on the same cycle, both update pulses rise on the same cycle.
- R9: If a latch input changes just after a system-clock edge, the update pulse and new outputs are visible after the third system-clock edge that follows. A bit-clock rise shifts its data bit after the same three-edge delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Shared serial bit clock (asynchronous) |
| sdat_l_i | input | 1 | Left serial data |
| sdat_r_i | input | 1 | Right serial data |
| ld_l_i | input | 1 | Left latch strobe, transfers on falling edge |
| ld_r_i | input | 1 | Right latch strobe, transfers on falling edge |
| seg_l_o | output | 15 | Left thermometer segment enables |
| lsb_l_o | output | 14 | Left binary low field |
| upd_l_o | output | 1 | Left update pulse |
| seg_r_o | output | 15 | Right thermometer segment enables |
| lsb_r_o | output | 14 | Right binary low field |
| upd_r_o | output | 1 | Right update pulse |

## Verification
A strobe or bit-clock change made just after an edge is captured by the first synchronizer flop at the next edge. It reaches the second flop one edge later and takes effect on the third edge. The new segments, binary field and update pulse are therefore due in the cycle after that third edge. The bench's reference model applies each input exactly three edges after it was driven and compares all six outputs half a cycle after every edge. Each latch task also checks directly that the pulse is absent after the first and second edges and present after the third.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int DEF_WORD_W   = 18;
    localparam int DEF_SEG_BITS = 4;

    typedef enum logic {
        LT_WAIT_HIGH = 1'b0,
        LT_ARMED     = 1'b1
    } latch_st_e;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage1 <= '0;
            q_o    <= '0;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
    import dacif_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bit_rise_i,
    input  logic              din_i,
    input  logic              latch_i,
    output logic [WORD_W-1:0] held_o,
    output logic              upd_o
);
    latch_st_e         st_q, st_d;
    logic              fire;
    logic [WORD_W-1:0] shift_q;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= LT_WAIT_HIGH;
        else       st_q <= st_d;
    end

    // next state and transfer decision
    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        unique case (st_q)
            LT_WAIT_HIGH: if (latch_i)  st_d = LT_ARMED;
            LT_ARMED:     if (!latch_i) begin
                st_d = LT_WAIT_HIGH;
                fire = 1'b1;
            end
        endcase
    end

    // data path: shift register, holding register, pulse
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shift_q <= '0;
            held_o  <= '0;
            upd_o   <= 1'b0;
        end else begin
            if (bit_rise_i) shift_q <= {shift_q[WORD_W-2:0], din_i};
            if (fire)       held_o  <= shift_q;
            upd_o <= fire;
        end
    end
endmodule

// File: rtl/dacif_therm.sv
module dacif_therm
    import dacif_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int SEG_BITS = DEF_SEG_BITS,
    localparam int SEG_N   = (1 << SEG_BITS) - 1,
    localparam int LSB_W   = WORD_W - SEG_BITS
) (
    input  logic [WORD_W-1:0] held_i,
    output logic [SEG_N-1:0]  seg_o,
    output logic [LSB_W-1:0]  lsb_o
);
    logic [SEG_BITS-1:0] level;

    // two's complement to offset binary on the top field
    assign level = {~held_i[WORD_W-1], held_i[WORD_W-2 -: SEG_BITS-1]};
    assign lsb_o = held_i[LSB_W-1:0];

    for (genvar i = 0; i < SEG_N; i++) begin : g_seg
        assign seg_o[i] = (level > SEG_BITS'(i));
    end
endmodule

// File: rtl/dacif_front.sv
module dacif_front
    import dacif_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int SEG_BITS = DEF_SEG_BITS,
    localparam int SEG_N   = (1 << SEG_BITS) - 1,
    localparam int LSB_W   = WORD_W - SEG_BITS
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sclk_i,
    input  logic             sdat_l_i,
    input  logic             sdat_r_i,
    input  logic             ld_l_i,
    input  logic             ld_r_i,
    output logic [SEG_N-1:0] seg_l_o,
    output logic [LSB_W-1:0] lsb_l_o,
    output logic             upd_l_o,
    output logic [SEG_N-1:0] seg_r_o,
    output logic [LSB_W-1:0] lsb_r_o,
    output logic             upd_r_o
);
    localparam int NCH = 2;

    logic [4:0]       raw, syn;
    logic             sclk_prev, bit_rise;
    logic [NCH-1:0]   din_s, latch_s, upd;
    logic [WORD_W-1:0] held [NCH];
    logic [SEG_N-1:0]  seg  [NCH];
    logic [LSB_W-1:0]  lsb  [NCH];

    assign raw = {ld_r_i, ld_l_i, sdat_r_i, sdat_l_i, sclk_i};

    dacif_sync #(.W(5)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw),
        .q_o   (syn)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) sclk_prev <= 1'b0;
        else       sclk_prev <= syn[0];
    end
    assign bit_rise = syn[0] & ~sclk_prev;

    assign din_s   = syn[2:1];
    assign latch_s = syn[4:3];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dacif_chan #(.WORD_W(WORD_W)) u_chan (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .bit_rise_i (bit_rise),
            .din_i      (din_s[c]),
            .latch_i    (latch_s[c]),
            .held_o     (held[c]),
            .upd_o      (upd[c])
        );
        dacif_therm #(.WORD_W(WORD_W), .SEG_BITS(SEG_BITS)) u_therm (
            .held_i (held[c]),
            .seg_o  (seg[c]),
            .lsb_o  (lsb[c])
        );
    end

    assign seg_l_o = seg[0];
    assign lsb_l_o = lsb[0];
    assign upd_l_o = upd[0];
    assign seg_r_o = seg[1];
    assign lsb_r_o = lsb[1];
    assign upd_r_o = upd[1];
endmodule

// File: rtl/dacif_front_chk.sv
module dacif_front_chk #(
    parameter int SEG_N = 15,
    parameter int LSB_W = 14,
    localparam logic [SEG_N-1:0] MID = SEG_N'((1 << ((SEG_N + 1) / 2)) - 1)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             ld_l_i,
    input logic             ld_r_i,
    input logic [SEG_N-1:0] seg_l_o,
    input logic [LSB_W-1:0] lsb_l_o,
    input logic             upd_l_o,
    input logic [SEG_N-1:0] seg_r_o,
    input logic [LSB_W-1:0] lsb_r_o,
    input logic             upd_r_o
);
    a_r1_reset_midscale: assert property (@(posedge clk_i)
        $past(rst_i) |-> (seg_l_o == MID && lsb_l_o == '0 && !upd_l_o &&
                          seg_r_o == MID && lsb_r_o == '0 && !upd_r_o));

    a_r4_pulse_single_l: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_l_o |=> !upd_l_o);
    a_r4_pulse_single_r: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_r_o |=> !upd_r_o);

    a_r4_hold_steady_l: assert property (@(posedge clk_i) disable iff (rst_i)
        !upd_l_o |-> ($stable(seg_l_o) && $stable(lsb_l_o)));
    a_r4_hold_steady_r: assert property (@(posedge clk_i) disable iff (rst_i)
        !upd_r_o |-> ($stable(seg_r_o) && $stable(lsb_r_o)));

    a_r5_therm_shape_l: assert property (@(posedge clk_i) disable iff (rst_i)
        ((seg_l_o + 1'b1) & seg_l_o) == '0);
    a_r5_therm_shape_r: assert property (@(posedge clk_i) disable iff (rst_i)
        ((seg_r_o + 1'b1) & seg_r_o) == '0);

    a_r3_fire_on_low_l: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_l_o |-> !$past(ld_l_i, 3));
    a_r3_fire_on_low_r: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_r_o |-> !$past(ld_r_i, 3));
endmodule

bind dacif_front dacif_front_chk #(.SEG_N(SEG_N), .LSB_W(LSB_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ld_l_i  (ld_l_i),
    .ld_r_i  (ld_r_i),
    .seg_l_o (seg_l_o),
    .lsb_l_o (lsb_l_o),
    .upd_l_o (upd_l_o),
    .seg_r_o (seg_r_o),
    .lsb_r_o (lsb_r_o),
    .upd_r_o (upd_r_o)
);

// File: tb/dacif_front_test.sv
module dacif_front_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, dl = 1'b0, dr = 1'b0, ll = 1'b0, lr = 1'b0;
    logic [14:0] seg_l, seg_r;
    logic [13:0] lsb_l, lsb_r;
    logic upd_l, upd_r;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dacif_front uut (
        .clk_i(clk), .rst_i(rst), .sclk_i(sclk),
        .sdat_l_i(dl), .sdat_r_i(dr), .ld_l_i(ll), .ld_r_i(lr),
        .seg_l_o(seg_l), .lsb_l_o(lsb_l), .upd_l_o(upd_l),
        .seg_r_o(seg_r), .lsb_r_o(lsb_r), .upd_r_o(upd_r)
    );

    function automatic logic [14:0] exp_seg(logic [17:0] w);
        int k;
        logic [14:0] s;
        k = int'({~w[17], w[16:14]});
        s = '0;
        for (int i = 0; i < 15; i++) if (i < k) s[i] = 1'b1;
        return s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: inputs act three edges after they are driven
    logic [4:0]  hist[$];
    logic [17:0] m_word[2], m_hold[2];
    bit          m_arm[2], m_upd[2];

    always @(posedge clk) begin
        if (rst) begin
            hist = {5'd0, 5'd0, 5'd0};
            for (int c = 0; c < 2; c++) begin
                m_word[c] = '0; m_hold[c] = '0; m_arm[c] = 0; m_upd[c] = 0;
            end
        end else begin
            logic [4:0] cur, old;
            hist.push_back({lr, ll, dr, dl, sclk});
            cur = hist[hist.size()-3];
            old = hist[hist.size()-4];
            if (hist.size() > 4) void'(hist.pop_front());
            for (int c = 0; c < 2; c++) begin
                m_upd[c] = 0;
                if (!m_arm[c] && cur[3+c]) m_arm[c] = 1;
                else if (m_arm[c] && !cur[3+c]) begin
                    m_hold[c] = m_word[c]; m_arm[c] = 0; m_upd[c] = 1;
                end
                if (cur[0] && !old[0]) m_word[c] = {m_word[c][16:0], cur[1+c]};
            end
        end
    end

    always @(negedge clk) if (!rst && !done) begin
        check("R5 seg_l", 32'(seg_l), 32'(exp_seg(m_hold[0])));
        check("R6 lsb_l", 32'(lsb_l), 32'(m_hold[0][13:0]));
        check("R4 upd_l", 32'(upd_l), 32'(m_upd[0]));
        check("R5 seg_r", 32'(seg_r), 32'(exp_seg(m_hold[1])));
        check("R6 lsb_r", 32'(lsb_r), 32'(m_hold[1][13:0]));
        check("R4 upd_r", 32'(upd_r), 32'(m_upd[1]));
    end

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R2: MSB first, one bit per bit-clock rise
    task automatic send(logic [31:0] wl, logic [31:0] wr, int n);
        for (int b = n - 1; b >= 0; b--) begin
            @(negedge clk); dl = wl[b]; dr = wr[b];
            wait_n(3); sclk = 1'b1;
            wait_n(3); sclk = 1'b0;
        end
        wait_n(4);
    endtask

    // R9 latency and R8 cophased pulses on strobes lowered together
    task automatic latch(bit do_l, bit do_r);
        @(negedge clk);
        if (do_l) ll = 1'b0;
        if (do_r) lr = 1'b0;
        wait_n(2);
        check("R9 no early pulse", 32'({upd_l, upd_r}), 32'b0);
        wait_n(1);
        check("R9/R8 pulse after third edge", 32'({upd_l, upd_r}), 32'({do_l, do_r}));
        wait_n(2); ll = 1'b1; lr = 1'b1;
        wait_n(5);
    endtask

    initial begin
        wait_n(5);
        check("R1 reset seg_l", 32'(seg_l), 32'h00FF);
        check("R1 reset lsb_r", 32'(lsb_r), 32'h0);
        @(negedge clk); rst = 1'b0;
        wait_n(2);
        check("R1 released seg_r", 32'(seg_r), 32'h00FF);
        check("R1 released upd", 32'({upd_l, upd_r}), 32'h0);
        ll = 1'b1; lr = 1'b1; wait_n(5);

        send(32'h3FFFF, 32'h3FFFF, 18);
        latch(1, 1);
        check("R5 minus one seg_l", 32'(seg_l), 32'h007F);
        check("R6 minus one lsb_r", 32'(lsb_r), 32'h3FFF);

        send(32'h1FFFF, 32'h20000, 18);
        latch(1, 0);
        check("R5 full-scale seg_l", 32'(seg_l), 32'h7FFF);
        check("R7 right untouched", 32'(seg_r), 32'h007F);
        latch(0, 1);
        check("R5 most negative seg_r", 32'(seg_r), 32'h0);
        check("R6 most negative lsb_r", 32'(lsb_r), 32'h0);
        check("R7 left untouched", 32'(seg_l), 32'h7FFF);

        send({14'h0, 4'hF, 18'h0ABCD}, {14'h0, 4'h0, 18'h0ABCD}, 22);
        latch(1, 1);
        check("R2 leading bits dropped seg_l", 32'(seg_l), 32'h03FF);
        check("R2 leading bits dropped lsb_r", 32'(lsb_r), 32'h2BCD);

        send(32'h15555, 32'h2AAAA, 18);
        check("R3 no latch, seg_l kept", 32'(seg_l), 32'h03FF);
        check("R3 no latch, lsb_r kept", 32'(lsb_r), 32'h2BCD);
        latch(1, 1);

        for (int t = 0; t < 10; t++) begin
            send(32'($urandom), 32'($urandom), 18);
            latch(t % 3 != 1, t % 3 != 2);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule